// File: doc/BRIEF.md
# Interleaved DDR I/Q Sample Transmitter

This block feeds a dual-channel DAC over one narrow, double-data-rate byte bus. It accepts pairs of in-phase and quadrature samples through a valid/ready handshake and splits each 16-bit sample into a high byte and a low byte. It sends those bytes on both edges of a forwarded data clock, so a single 8-bit lane carries both channels. One sample pair takes four bytes, which is two data-clock cycles. The in-phase sample goes first and the quadrature sample second. In each cycle the high byte rides the rising edge and the low byte the falling edge.

Next to the bytes, the block drives a frame strobe. The strobe rises once every eight sample pairs, which is every sixteen data-clock cycles, and it always rises on the in-phase high byte of a pair. When the sample source is narrower than 16 bits, the unused low bits of every word are sent as zero. A static-pattern mode replaces the stream with two fixed words so that the receiver can check the bus. If no new sample is offered at a pair boundary, the previous pair is sent again and an underflow flag is raised.

The required data-clock rate is the channel count times the sample rate times the sample width, divided by the bus width times two edges. Elaboration rejects any parameter set whose required rate exceeds 312.5 MHz. Such a configuration has to lower the input sample rate and raise the DAC interpolation factor instead.

Top module: `iq_ddr_tx`

## Requirements
- R1: While reset is held, the data bus, the frame strobe and the underflow flag are all 0, and `src_ready` is 0.
- R2: Each pair takes two clock cycles. The first cycle carries I[15:8] on the high clock phase and I[7:0] on the low phase. The second cycle carries Q[15:8] on the high phase and Q[7:0] on the low phase.
- R3: `src_ready` is 1 only in the first cycle of a pair slot, and only when pattern mode is off. A pair is taken on the rising edge that ends that cycle, and its I bytes appear in the cycle that follows.
- R4: If `src_valid` is 0 at a pair boundary, the previously accepted pair is sent again.
- R5: `underflow` is 1 for the two cycles of a pair that was re-sent, and is 0 for pairs that were accepted or patterned.
- R6: The frame strobe is high for the first 8 cycles of each 16-cycle frame and low for the other 8. Its first rise after reset falls on the I high byte of the first pair.
- R7: With a 12-bit source (SRC_W=12), sample bits [3:0] of each word are sent as 0 and the source value occupies bits [15:4].
- R8: While `pattern_en` is 1 at a pair boundary, that pair is sent as PAT_I = 16'hA53C and PAT_Q = 16'h5AC3 in the R2 byte order. No source sample is consumed, and the held pair is left unchanged.
- R9: `dac_dclk` is the block clock forwarded unchanged.
- R10: Elaboration fails if the required data-clock rate (channels × sample rate × sample width / (bus width × 2)) exceeds 312.5 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-clock-rate block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Sample pair offered |
| src_ready | output | 1 | Pair is taken at this edge |
| src_i | input | SRC_W | In-phase sample |
| src_q | input | SRC_W | Quadrature sample |
| pattern_en | input | 1 | Send the fixed test words |
| dac_dclk | output | 1 | Forwarded data clock |
| dac_data | output | BUS_W | DDR byte lane |
| dac_frame | output | 1 | Frame strobe |
| underflow | output | 1 | Current pair is a repeat |

## Verification
The bench drives sample pairs whose top and bottom bytes differ from each other. A design that swapped edges, swapped channels or sent bytes in the wrong order would therefore show a wrong byte in a specific phase. It leaves gaps in the stream to confirm that the last accepted pair is repeated and flagged, rather than a zero or stale Q value being sent. It toggles pattern mode and then starves the source, to show that pattern words never overwrite the held pair. It also follows the frame strobe across more than one 16-cycle period, so an off-by-one period or a strobe that starts on a Q byte would be caught.

// File: rtl/iqtx_pkg.sv
package iqtx_pkg;
   typedef enum logic {SLOT_I = 1'b0, SLOT_Q = 1'b1} slot_e;

   function automatic longint dclk_khz(input int chans, input longint ksps,
                                       input int samp_w, input int bus_w);
      return (chans * ksps * samp_w) / (bus_w * 2);
   endfunction
endpackage

// File: rtl/iqtx_byte_seq.sv
module iqtx_byte_seq
   import iqtx_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int SAMP_W = 2 * BUS_W,
   parameter logic [SAMP_W-1:0] PAT_I = '0,
   parameter logic [SAMP_W-1:0] PAT_Q = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SAMP_W-1:0] in_i,
   input  logic [SAMP_W-1:0] in_q,
   input  logic              pat_en,
   output logic              in_ready,
   output logic [BUS_W-1:0]  nxt_hi,
   output logic [BUS_W-1:0]  nxt_lo,
   output logic              slot_is_q,
   output logic              pat_q_o,
   output logic              under_o
);
   slot_e             slot_r;
   logic [SAMP_W-1:0] held_i, held_q;
   logic              pat_r, under_r;
   logic [SAMP_W-1:0] word;

   assign in_ready = rst_n && (slot_r == SLOT_I) && !pat_en;

   always_comb begin
      if (slot_r == SLOT_I) begin
         if (pat_en)        word = PAT_I;
         else if (in_valid) word = in_i;
         else               word = held_i;
      end else begin
         word = pat_r ? PAT_Q : held_q;
      end
   end

   assign nxt_hi = word[SAMP_W-1:BUS_W];
   assign nxt_lo = word[BUS_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_r  <= SLOT_I;
         held_i  <= '0;
         held_q  <= '0;
         pat_r   <= 1'b0;
         under_r <= 1'b0;
      end else begin
         slot_r <= (slot_r == SLOT_I) ? SLOT_Q : SLOT_I;
         if (slot_r == SLOT_I) begin
            pat_r   <= pat_en;
            under_r <= !pat_en && !in_valid;
            if (!pat_en && in_valid) begin
               held_i <= in_i;
               held_q <= in_q;
            end
         end
      end
   end

   assign slot_is_q = (slot_r == SLOT_Q);
   assign pat_q_o   = pat_r;
   assign under_o   = under_r;

   // R3: ready alternates, never two cycles in a row
   p_ready_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> !in_ready);
   // R4, R8: starved or patterned boundaries leave the held pair untouched
   p_hold_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_r == SLOT_I) && (!in_valid || pat_en)) |=> ($stable(held_i) && $stable(held_q)));
   // R5: flag rises only after a starved ready cycle
   p_under_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(under_r) |-> $past(in_ready && !in_valid));
endmodule

// File: rtl/iqtx_frame_gen.sv
module iqtx_frame_gen #(
   parameter int FRAME_PAIRS = 8,
   parameter int CYC_PER_PAIR = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic frame_nxt
);
   localparam int FRAME_CYC = FRAME_PAIRS * CYC_PER_PAIR;
   localparam int HALF_CYC = FRAME_CYC / 2;
   localparam int CNT_W = (FRAME_CYC > 1) ? $clog2(FRAME_CYC) : 1;

   logic [CNT_W-1:0] cnt_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cnt_r <= '0;
      else if (cnt_r == CNT_W'(FRAME_CYC - 1))      cnt_r <= '0;
      else                                          cnt_r <= cnt_r + 1'b1;
   end

   assign frame_nxt = rst_n && (cnt_r < CNT_W'(HALF_CYC));
endmodule

// File: rtl/iqtx_ddr_out.sv
module iqtx_ddr_out #(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] hi_d,
   input  logic [BUS_W-1:0] lo_d,
   input  logic             frame_d,
   output logic [BUS_W-1:0] lo_q,
   output logic [BUS_W-1:0] pad_data,
   output logic             pad_frame,
   output logic             pad_clk
);
   logic [BUS_W-1:0] hi_r, lo_r;
   logic             frame_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_r    <= '0;
         lo_r    <= '0;
         frame_r <= 1'b0;
      end else begin
         hi_r    <= hi_d;
         lo_r    <= lo_d;
         frame_r <= frame_d;
      end
   end

   // dual-edge output stage: high phase shows the rising-edge byte
   assign pad_data  = clk ? hi_r : lo_r;
   assign pad_frame = frame_r;
   assign pad_clk   = clk;
   assign lo_q      = lo_r;
endmodule

// File: rtl/iq_ddr_tx.sv
module iq_ddr_tx
   import iqtx_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int SRC_W = 12,
   parameter int CHANNELS = 2,
   parameter int FRAME_PAIRS = 8,
   parameter longint SAMPLE_KSPS = 153600,
   parameter longint MAX_DCLK_KHZ = 312500,
   parameter logic [2*BUS_W-1:0] PAT_I = 16'hA53C,
   parameter logic [2*BUS_W-1:0] PAT_Q = 16'h5AC3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_valid,
   output logic             src_ready,
   input  logic [SRC_W-1:0] src_i,
   input  logic [SRC_W-1:0] src_q,
   input  logic             pattern_en,
   output logic             dac_dclk,
   output logic [BUS_W-1:0] dac_data,
   output logic             dac_frame,
   output logic             underflow
);
   localparam int SAMP_W = 2 * BUS_W;
   localparam int PAD_W = SAMP_W - SRC_W;
   localparam longint NEED_KHZ = dclk_khz(CHANNELS, SAMPLE_KSPS, SAMP_W, BUS_W);

   generate
      if (SRC_W > SAMP_W || SRC_W < 1)
         $error("iq_ddr_tx: SRC_W must lie in 1..2*BUS_W");
      if (CHANNELS != 2)
         $error("iq_ddr_tx: byte sequencer interleaves exactly two channels");
      if (FRAME_PAIRS < 1)
         $error("iq_ddr_tx: FRAME_PAIRS must be positive");
      if (NEED_KHZ > MAX_DCLK_KHZ)  // R10
         $error("iq_ddr_tx: data clock too fast, raise DAC interpolation");
   endgenerate

   logic [SAMP_W-1:0] wide_i, wide_q;
   generate
      if (PAD_W > 0) begin : g_pad
         assign wide_i = {src_i, {PAD_W{1'b0}}};
         assign wide_q = {src_q, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign wide_i = src_i;
         assign wide_q = src_q;
      end
   endgenerate

   logic [BUS_W-1:0] nxt_hi, nxt_lo, lo_q;
   logic             slot_is_q, pat_q, frame_nxt;

   iqtx_byte_seq #(.BUS_W(BUS_W), .SAMP_W(SAMP_W), .PAT_I(PAT_I), .PAT_Q(PAT_Q)) seq_i (
      .clk(clk), .rst_n(rst_n), .in_valid(src_valid), .in_i(wide_i), .in_q(wide_q),
      .pat_en(pattern_en), .in_ready(src_ready), .nxt_hi(nxt_hi), .nxt_lo(nxt_lo),
      .slot_is_q(slot_is_q), .pat_q_o(pat_q), .under_o(underflow));

   iqtx_frame_gen #(.FRAME_PAIRS(FRAME_PAIRS), .CYC_PER_PAIR(2)) frm_i (
      .clk(clk), .rst_n(rst_n), .frame_nxt(frame_nxt));

   iqtx_ddr_out #(.BUS_W(BUS_W)) ddr_i (
      .clk(clk), .rst_n(rst_n), .hi_d(nxt_hi), .lo_d(nxt_lo), .frame_d(frame_nxt),
      .lo_q(lo_q), .pad_data(dac_data), .pad_frame(dac_frame), .pad_clk(dac_dclk));

   // R6: frame rises while the I bytes of a pair are on the bus
   p_frame_on_i_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_frame) |-> slot_is_q);

   generate
      if (PAD_W > 0 && PAD_W <= BUS_W) begin : g_lsb_chk
         // R7: padded low bits of source words are zero on the bus
         p_lsb_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !pat_q |-> (lo_q[PAD_W-1:0] == '0));
      end
   endgenerate
endmodule

// File: tb/iq_ddr_tx_tb.sv
module iq_ddr_tx_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic src_valid = 1'b0;
   logic pattern_en = 1'b0;
   logic [11:0] src_i = '0, src_q = '0;
   logic src_ready, dac_dclk, dac_frame, underflow;
   logic [7:0] dac_data;

   always #2.5 clk = ~clk;

   iq_ddr_tx dut_i (.clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
      .src_i(src_i), .src_q(src_q), .pattern_en(pattern_en), .dac_dclk(dac_dclk),
      .dac_data(dac_data), .dac_frame(dac_frame), .underflow(underflow));

   int n_chk = 0, n_bad = 0, k = 0;
   bit done = 1'b0;
   logic [15:0] held_i = '0, held_q = '0;

   // {valid, I(12), Q(12)}
   localparam logic [24:0] VEC [12] = '{
      {1'b1, 12'h123, 12'h456}, {1'b1, 12'hFFF, 12'h000}, {1'b1, 12'h800, 12'h7FF},
      {1'b0, 12'h111, 12'h222}, {1'b1, 12'hABC, 12'hDEF}, {1'b1, 12'h001, 12'hF0F},
      {1'b0, 12'h333, 12'h444}, {1'b0, 12'h555, 12'h666}, {1'b1, 12'h5A5, 12'hA5A},
      {1'b1, 12'h0F0, 12'h00F}, {1'b1, 12'h7E1, 12'h18E}, {1'b1, 12'h246, 12'h8AC}};

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (k=%0d)", tag, act, exp, k);
      end
   endtask

   // one pair slot; inputs are driven now, before the boundary edge
   task automatic do_pair(input bit v, input logic [11:0] ii, input logic [11:0] qq, input bit pat);
      logic [15:0] ei, eq;
      src_valid = v; src_i = ii; src_q = qq; pattern_en = pat;
      #0.5;
      chk("R3 ready at boundary", {15'b0, src_ready}, {15'b0, !pat});
      if (pat) begin ei = 16'hA53C; eq = 16'h5AC3; end
      else begin
         if (v) begin held_i = {ii, 4'h0}; held_q = {qq, 4'h0}; end
         ei = held_i; eq = held_q;
      end
      @(posedge clk); #1;
      chk("R2 I high byte", {8'h0, dac_data}, {8'h0, ei[15:8]});
      chk("R6 frame", {15'b0, dac_frame}, {15'b0, (k % 16) < 8});
      chk("R9 dclk", {15'b0, dac_dclk}, 16'h1);
      @(negedge clk); #1;
      chk("R2 I low byte R7", {8'h0, dac_data}, {8'h0, ei[7:0]});
      chk("R3 ready off mid-pair", {15'b0, src_ready}, 16'h0);
      chk("R5 underflow", {15'b0, underflow}, {15'b0, (!v && !pat)});
      k++;
      src_valid = 1'b0;
      @(posedge clk); #1;
      chk("R2 Q high byte", {8'h0, dac_data}, {8'h0, eq[15:8]});
      chk("R6 frame", {15'b0, dac_frame}, {15'b0, (k % 16) < 8});
      @(negedge clk); #1;
      chk("R2 Q low byte R7", {8'h0, dac_data}, {8'h0, eq[7:0]});
      chk("R5 underflow held", {15'b0, underflow}, {15'b0, (!v && !pat)});
      k++;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset data high phase", {8'h0, dac_data}, 16'h0);
      chk("R1 reset frame", {15'b0, dac_frame}, 16'h0);
      chk("R1 reset underflow", {15'b0, underflow}, 16'h0);
      chk("R1 reset ready", {15'b0, src_ready}, 16'h0);
      @(negedge clk); #1;
      chk("R1 reset data low phase", {8'h0, dac_data}, 16'h0);
      rst_n = 1'b1;
      // table walk: R2 R3 R4 R5 R6 R7
      for (int n = 0; n < 12; n++)
         do_pair(VEC[n][24], VEC[n][23:12], VEC[n][11:0], 1'b0);
      // R8: pattern words, source ignored even with valid high
      do_pair(1'b1, 12'h999, 12'h999, 1'b1);
      do_pair(1'b1, 12'h999, 12'h999, 1'b1);
      // R8/R4: starved after pattern resends the last real pair, not 0x999
      do_pair(1'b0, 12'h000, 12'h000, 1'b0);
      do_pair(1'b1, 12'hC3C, 12'h3C3, 1'b0);
      do_pair(1'b0, 12'h000, 12'h000, 1'b0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule